// File: doc/BRIEF.md
# Flash Write Qualification and Protection Gate

This block sits between the asynchronous bus pins of a parallel NOR flash and its command logic. The three active-low control lines pass through two-flop synchronisers and a width filter, and the gate then decides whether a bus cycle is a real write. A write begins when chip-enable and write-enable are both low and output-enable is high. Any other combination inhibits it. The gate latches the address when the write begins. It latches the data and issues a one-cycle strobe when the write ends.

The gate refuses writes in three cases. The first is a low-supply lockout, which also resets the command state. The second is a write already held active when power-up completes. The third is a program or erase aimed at a write-protected sector. A high-voltage indication on the reset pin lifts sector protection for as long as it is present. It does not alter the stored protect bits, so protection returns as soon as the indication goes away.

Top module: `flash_wr_gate`

## Requirements
- R1: A cycle with ce_n=0, we_n=0, oe_n=1 held for at least FILT_N clocks ends with exactly one wr_stb. wr_addr holds the address present when the write began, and wr_data holds din from when it ended.
- R2: A cycle in which oe_n is low, or chip-enable stays high while write-enable pulses, produces no wr_stb and no prot_viol.
- R3: A low pulse on we_n or ce_n shorter than FILT_N clocks (after synchronisation) starts no write.
- R4: While low_vcc is high, no write is accepted, and a write in progress when it rises is dropped. Each rise of low_vcc gives one cmd_rst pulse. Writes are accepted again once low_vcc falls.
- R5: After reset release, cmd_rst pulses for exactly one cycle, which returns the command logic to read-array mode.
- R6: If ce_n=0, we_n=0 and oe_n=1 are already present at reset release, the following rise of we_n produces no wr_stb. The inhibit clears once ce_n or we_n has been seen high.
- R7: The sector index is the top log2(N_SECT) bits of the address latched when the write began. A write ending with pe_req=1 whose sector has sect_prot bit set, and hv_on_rst=0, produces no wr_stb and a one-cycle prot_viol.
- R8: While hv_on_rst is high, a write with pe_req=1 to a protected sector gives wr_stb and no prot_viol.
- R9: After hv_on_rst falls, writes with pe_req=1 to the same protected sectors are again blocked with prot_viol.
- R10: A write with pe_req=0 to a protected sector, such as an unlock cycle, is passed with wr_stb.
- R11: wr_stb and prot_viol are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| low_vcc | input | 1 | Supply below lockout threshold, asynchronous |
| hv_on_rst | input | 1 | High voltage present on reset pin, asynchronous |
| pe_req | input | 1 | Command logic marks the current write as a program or erase target |
| addr | input | ADDR_W | Bus address |
| din | input | DATA_W | Bus write data |
| sect_prot | input | N_SECT | Stored per-sector protect bits |
| wr_stb | output | 1 | Qualified write strobe, one cycle |
| wr_addr | output | ADDR_W | Address latched at write start |
| wr_data | output | DATA_W | Data latched at write end |
| cmd_rst | output | 1 | Command-state reset pulse |
| prot_viol | output | 1 | Blocked protected-sector write, one cycle |

## Verification
A supply lockout can arrive while a write is in flight. In that case the gate must reset the command state and must also drop the write that ends later. The bench raises low_vcc in the middle of an otherwise valid cycle and releases it only after write-enable has risen. It then expects one extra cmd_rst pulse and no strobe from the scoreboard. A write made right after the lockout clears must still come through.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } fwg_ctl_t;

  localparam fwg_ctl_t CTL_RST = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1};

  function automatic logic ctl_writes(fwg_ctl_t c);
    return (!c.ce_n) && (!c.we_n) && c.oe_n;
  endfunction

endpackage

// File: rtl/fwg_sync.sv
module fwg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fwg_deglitch.sv
module fwg_deglitch #(
  parameter int          W       = 3,
  parameter int          N       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] filt
);
  localparam int CW = (N > 1) ? $clog2(N + 1) : 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [CW-1:0] cnt_q, cnt_d;
    logic          val_q, val_d;

    always_comb begin
      cnt_d = cnt_q;
      val_d = val_q;
      if (raw[b] == val_q) begin
        cnt_d = '0;
      end else if (cnt_q == CW'(N - 1)) begin
        val_d = raw[b];
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        val_q <= RST_VAL[b];
      end else begin
        cnt_q <= cnt_d;
        val_q <= val_d;
      end
    end

    assign filt[b] = val_q;
  end
endmodule

// File: rtl/fwg_qual.sv
module fwg_qual
  import fwg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  fwg_ctl_t ctl,
  input  logic     lock,
  output logic     start_ok,
  output logic     fin_ok,
  output logic     pu_blk,
  output logic     armed
);
  logic wact, wact_q;
  logic rise_w, fall_w;
  logic armed_d, pu_d;

  assign wact   = ctl_writes(ctl);
  assign rise_w = wact && !wact_q;
  assign fall_w = !wact && wact_q;

  assign start_ok = rise_w && !pu_blk && !lock;
  assign fin_ok   = fall_w && armed && !lock;

  always_comb begin
    armed_d = armed;
    if (lock)          armed_d = 1'b0;
    else if (start_ok) armed_d = 1'b1;
    else if (fall_w)   armed_d = 1'b0;
    pu_d = pu_blk && !(ctl.ce_n || ctl.we_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wact_q <= 1'b1;
      armed  <= 1'b0;
      pu_blk <= 1'b1;
    end else begin
      wact_q <= wact;
      armed  <= armed_d;
      pu_blk <= pu_d;
    end
  end
endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate
  import fwg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int N_SECT = 8,
  parameter int FILT_N = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              low_vcc,
  input  logic              hv_on_rst,
  input  logic              pe_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [N_SECT-1:0] sect_prot,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              cmd_rst,
  output logic              prot_viol
);
  localparam int SECT_W = (N_SECT > 1) ? $clog2(N_SECT) : 1;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  fwg_ctl_t ctl_raw, ctl_s, ctl_f;
  logic [1:0] stat_s;
  logic lock_s, hv_s;

  assign ctl_raw = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};

  fwg_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(CTL_RST)) u_sync_ctl (
    .clk(clk), .rst_n(rst_sync_n), .d(ctl_raw), .q(ctl_s));

  fwg_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b00)) u_sync_stat (
    .clk(clk), .rst_n(rst_sync_n), .d({low_vcc, hv_on_rst}), .q(stat_s));

  assign lock_s = stat_s[1];
  assign hv_s   = stat_s[0];

  fwg_deglitch #(.W(3), .N(FILT_N), .RST_VAL(CTL_RST)) u_filt (
    .clk(clk), .rst_n(rst_sync_n), .raw(ctl_s), .filt(ctl_f));

  logic start_ok, fin_ok, pu_blk, armed;

  fwg_qual u_qual (
    .clk(clk), .rst_n(rst_sync_n), .ctl(ctl_f), .lock(lock_s),
    .start_ok(start_ok), .fin_ok(fin_ok), .pu_blk(pu_blk), .armed(armed));

  logic [SECT_W-1:0] sect_idx;
  logic              blocked;
  logic              boot_q, lock_q;
  logic              stb_d, viol_d, crst_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;

  always_comb begin
    sect_idx = wr_addr[ADDR_W-1 -: SECT_W];
    blocked  = pe_req && sect_prot[sect_idx] && !hv_s;
    stb_d    = fin_ok && !blocked;
    viol_d   = fin_ok && blocked;
    crst_d   = boot_q || (lock_s && !lock_q);
    addr_d   = start_ok ? addr : wr_addr;
    data_d   = stb_d ? din : wr_data;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_stb    <= 1'b0;
      prot_viol <= 1'b0;
      cmd_rst   <= 1'b0;
      boot_q    <= 1'b1;
      lock_q    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_stb    <= stb_d;
      prot_viol <= viol_d;
      cmd_rst   <= crst_d;
      boot_q    <= 1'b0;
      lock_q    <= lock_s;
      wr_addr   <= addr_d;
      wr_data   <= data_d;
    end
  end
endmodule

// File: rtl/fwg_chk.sv
module fwg_chk (
  input logic clk,
  input logic srst_n,
  input logic lock,
  input logic hv,
  input logic pu_blk,
  input logic armed,
  input logic pe_req,
  input logic wr_stb,
  input logic prot_viol,
  input logic cmd_rst
);
  // R11
  stb_viol_excl_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_stb |-> !prot_viol);

  // R11
  stb_single_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_stb |=> !wr_stb);

  // R4
  lock_no_stb_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (lock && $past(lock)) |-> !wr_stb);

  // R6
  pu_no_stb_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_stb |-> !$past(pu_blk));

  // R7
  viol_cause_chk: assert property (@(posedge clk) disable iff (!srst_n)
    prot_viol |-> $past(!hv && pe_req));

  // R1
  stb_armed_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wr_stb |-> $past(armed));

  // R5
  crst_pulse_chk: assert property (@(posedge clk) disable iff (!srst_n)
    cmd_rst |=> !cmd_rst);
endmodule

bind flash_wr_gate fwg_chk u_chk (
  .clk(clk), .srst_n(rst_sync_n), .lock(lock_s), .hv(hv_s),
  .pu_blk(pu_blk), .armed(armed), .pe_req(pe_req),
  .wr_stb(wr_stb), .prot_viol(prot_viol), .cmd_rst(cmd_rst));

// File: tb/tb_flash_wr_gate.sv
`timescale 1ns/1ps
module tb_flash_wr_gate;
  localparam int AW = 12, DW = 16, NS = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ce_n, we_n, oe_n, low_vcc, hv_on_rst, pe_req;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [NS-1:0] sect_prot;
  logic wr_stb, cmd_rst, prot_viol;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  flash_wr_gate dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .low_vcc(low_vcc), .hv_on_rst(hv_on_rst), .pe_req(pe_req),
    .addr(addr), .din(din), .sect_prot(sect_prot),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_rst(cmd_rst), .prot_viol(prot_viol));

  typedef struct {
    bit            viol;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t  q[$];
  int    total = 0, bad = 0, crst_cnt = 0;
  string cur_req = "R1";
  bit    finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (cmd_rst) crst_cnt++;
    if (wr_stb || prot_viol) begin
      if (q.size() == 0) begin
        chk(0, cur_req, "unexpected output stb/viol", {wr_stb, prot_viol}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(prot_viol == e.viol && wr_stb == !e.viol, e.tag, "kind stb/viol",
            {wr_stb, prot_viol}, {!e.viol, e.viol});
        if (!e.viol) begin
          chk(wr_addr == e.a, e.tag, "wr_addr", wr_addr, e.a);
          chk(wr_data == e.d, e.tag, "wr_data", wr_data, e.d);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // kind: 0 strobe expected, 1 violation expected, 2 nothing expected
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic pe, input int kind, input string tag);
    if (kind < 2) begin
      exp_t e;
      e.viol = (kind == 1); e.a = a; e.d = d; e.tag = tag;
      q.push_back(e);
    end
    cur_req = tag;
    @(negedge clk);
    addr = a; din = d; pe_req = pe; ce_n = 1'b0;
    idle(1);
    we_n = 1'b0;
    idle(5);
    we_n = 1'b1;
    idle(2);
    ce_n = 1'b1;
    idle(12);
    pe_req = 1'b0;
    chk(q.size() == 0, tag, "scoreboard drained", q.size(), 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    low_vcc = 1'b0; hv_on_rst = 1'b0; pe_req = 1'b0;
    addr = '0; din = '0; sect_prot = 8'b0000_0101;
    cur_req = "R6";
    idle(3);
    rst_n = 1'b1;
    idle(12);
    chk(wr_stb == 1'b0 && prot_viol == 1'b0, "R5", "reset outputs",
        {wr_stb, prot_viol}, 0);
    chk(crst_cnt == 1, "R5", "cmd_rst pulses after reset", crst_cnt, 1);
    // R6: write already active at power-up: the rise of we_n is not taken
    we_n = 1'b1;
    idle(12);
    ce_n = 1'b1;
    idle(8);
    chk(q.size() == 0 && !wr_stb, "R6", "no strobe from power-up cycle", wr_stb, 0);
    wr(12'h2F0, 16'h1234, 1'b0, 0, "R6");

    // R1: normal writes
    wr(12'h6A1, 16'hBEEF, 1'b1, 0, "R1");
    wr(12'h155, 16'h0F0F, 1'b0, 0, "R1");

    // R2: output enable low inhibits
    oe_n = 1'b0;
    wr(12'h300, 16'hAAAA, 1'b0, 2, "R2");
    oe_n = 1'b1;
    // R2: we pulses with chip-enable high
    cur_req = "R2";
    we_n = 1'b0; idle(6); we_n = 1'b1; idle(12);
    chk(q.size() == 0, "R2", "ce high inhibits", q.size(), 0);

    // R3: short pulses
    cur_req = "R3";
    ce_n = 1'b0; idle(3);
    we_n = 1'b0; idle(1); we_n = 1'b1; idle(10);
    ce_n = 1'b1; idle(4);
    we_n = 1'b0; idle(2);
    ce_n = 1'b0; idle(1); ce_n = 1'b1; idle(3);
    we_n = 1'b1; idle(10);
    chk(q.size() == 0, "R3", "glitches ignored", q.size(), 0);
    wr(12'h3C3, 16'h5A5A, 1'b0, 0, "R3");

    // R7 / R10: protected sectors 0 and 2
    wr(12'h0AB, 16'h1111, 1'b1, 1, "R7");
    wr(12'h0AB, 16'h2222, 1'b0, 0, "R10");
    // R8: override
    hv_on_rst = 1'b1; idle(4);
    wr(12'h4CD, 16'h3333, 1'b1, 0, "R8");
    hv_on_rst = 1'b0; idle(4);
    // R9: protection back
    wr(12'h4CD, 16'h4444, 1'b1, 1, "R9");
    wr(12'h0FF, 16'h4545, 1'b1, 1, "R9");

    // R4: lockout arriving mid-write
    c0 = crst_cnt;
    cur_req = "R4";
    @(negedge clk);
    addr = 12'h250; din = 16'h7777; ce_n = 1'b0; idle(1);
    we_n = 1'b0; idle(6);
    low_vcc = 1'b1; idle(4);
    we_n = 1'b1; idle(2); ce_n = 1'b1; idle(10);
    chk(crst_cnt == c0 + 1, "R4", "cmd_rst on lockout", crst_cnt, c0 + 1);
    chk(q.size() == 0, "R4", "write dropped by lockout", q.size(), 0);
    wr(12'h251, 16'h8888, 1'b0, 2, "R4");
    low_vcc = 1'b0; idle(5);
    chk(crst_cnt == c0 + 1, "R4", "single cmd_rst per lockout", crst_cnt, c0 + 1);
    wr(12'h252, 16'h9999, 1'b0, 0, "R4");

    idle(5);
    chk(q.size() == 0, "R11", "final scoreboard empty", q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule